// File: doc/BRIEF.md
# Valid/Invalid Snooping Coherence Controller

This block sits beside one data cache and keeps one coherence bit per line under a two-state Valid/Invalid protocol. It has a small direct-mapped tag store. Each entry holds a tag, a state bit and a dirty flag. The tag store is indexed by the line-index field of an address. The local processor presents one access at a time. The controller answers it one cycle later with a hit or miss indication. When needed, it also issues a one-cycle broadcast request toward the shared bus: a read for a read miss, and a write for a write miss or a write hit. Arbitration of that request belongs to another block.

In the other direction, the controller observes every bus transaction and looks up the snooped address in the same tag store. It acts only on transactions tagged with another cache's source number, and only while the snoop enable input is high. A snooped write that hits a Valid line invalidates that line. A snooped read that hits leaves the line Valid. In both cases a hit on a line holding data not yet written back raises a cache-to-cache supply pulse carrying the snooped address, and the dirty flag is then cleared. The snoop and the local access share one lookup port, so a qualifying snoop takes that port and the local access is stalled for that cycle.

Top module: `vi_snoop_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid, so the first local access to any address reports a miss. The cycle after reset, cpu_ack, bus_valid and c2c_supply are all 0.
- R2: An accepted local access (cpu_req high, cpu_stall low) produces cpu_ack=1 on the next cycle. On a miss it reports cpu_hit=0 and issues bus_valid=1 with bus_wr equal to cpu_wr (1 = write, 0 = read) and bus_addr equal to cpu_addr. The line becomes Valid with the access's tag.
- R3: An accepted access that finds a Valid line with a matching tag reports cpu_hit=1 and leaves the line Valid. A read hit issues no bus transaction.
- R4: A local write hit issues bus_valid=1 with bus_wr=1 and bus_addr equal to cpu_addr.
- R5: A qualifying snooped write (snp_wr=1) that matches a Valid line makes it Invalid, so the next local access to that address misses.
- R6: A qualifying snooped read (snp_wr=0) that matches a Valid line leaves it Valid, so the next local access to that address hits.
- R7: A snooped transaction whose snp_src equals the MY_ID parameter is ignored. It causes no stall, no supply and no state change.
- R8: A qualifying snoop that matches a Valid line with its dirty flag set gives c2c_supply=1 and c2c_addr=snp_addr on the next cycle, then clears the dirty flag. A clean line gives no supply. The dirty flag is set by any local write.
- R9: A qualifying snoop (snp_valid, snoop_en, snp_src not MY_ID) has priority over a local access in the same cycle. cpu_stall is 1 in that cycle and the access is accepted once no qualifying snoop is present.
- R10: With snoop_en=0, snooped transactions are ignored. They cause no stall, no supply and no state change.
- R11: A snoop whose tag differs from the stored tag at that index leaves the line untouched. A local access with a different tag misses and replaces the stored tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snoop_en | input | 1 | Enables reaction to snooped transactions |
| cpu_req | input | 1 | Local access request; drop after the cycle it is accepted |
| cpu_wr | input | 1 | Local access is a write |
| cpu_addr | input | ADDR_W | Local access byte address |
| cpu_stall | output | 1 | Local access not accepted this cycle (snoop has the lookup port) |
| cpu_ack | output | 1 | Registered: an access was accepted last cycle |
| cpu_hit | output | 1 | Registered: the accepted access hit |
| bus_valid | output | 1 | Registered one-cycle broadcast request |
| bus_wr | output | 1 | Broadcast is a write (1) or a read (0) |
| bus_addr | output | ADDR_W | Broadcast address |
| snp_valid | input | 1 | A transaction is on the bus |
| snp_wr | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped address |
| snp_src | input | SRC_W | Source number of the cache issuing the transaction |
| c2c_supply | output | 1 | Registered: this cache supplies the snooped line |
| c2c_addr | output | ADDR_W | Address of the supplied line |

## Verification
The assertions check the handshake rules on every cycle: the stall when a snoop arrives with a local request, the acknowledge after each accepted access, the broadcast rules for misses and write hits, the silence of read hits, and the absence of supply when snooping is off or the source is this cache. Only the bench's scenarios can show the state effects, because they appear as the hit or miss of a later access. These include invalidation by a remote write, survival of a line after a remote read, the dirty flag cleared after a supply, and replacement on a tag conflict. A reference model of the tag store in the bench predicts those outcomes for random mixes of local and snooped traffic.

// File: rtl/vi_pkg.sv
package vi_pkg;
  typedef enum logic { LS_INV = 1'b0, LS_VAL = 1'b1 } line_state_e;
endpackage

// File: rtl/vi_tag_store.sv
module vi_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 23
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    idx,
  output logic [TAG_W-1:0]    rd_tag,
  output vi_pkg::line_state_e rd_state,
  output logic                rd_dirty,
  input  logic                wr_en,
  input  logic [TAG_W-1:0]    wr_tag,
  input  vi_pkg::line_state_e wr_state,
  input  logic                wr_dirty
);
  localparam int LINES = 1 << IDX_W;

  // tags carry no reset: a plain array that maps to distributed RAM
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= (wr_state == vi_pkg::LS_VAL);
      dirty_q[idx] <= wr_dirty;
    end
  end

  assign rd_tag   = tag_mem[idx];
  assign rd_state = valid_q[idx] ? vi_pkg::LS_VAL : vi_pkg::LS_INV;
  assign rd_dirty = dirty_q[idx];
endmodule

// File: rtl/vi_match.sv
module vi_match #(
  parameter int TAG_W = 23
) (
  input  logic [TAG_W-1:0]    look_tag,
  input  logic [TAG_W-1:0]    store_tag,
  input  vi_pkg::line_state_e store_state,
  output logic                hit
);
  assign hit = (store_state == vi_pkg::LS_VAL) && (look_tag == store_tag);
endmodule

// File: rtl/vi_snoop_ctrl.sv
module vi_snoop_ctrl #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 4,
  parameter int SRC_W  = 3,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snoop_en,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_stall,
  output logic              cpu_ack,
  output logic              cpu_hit,
  output logic              bus_valid,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              snp_valid,
  input  logic              snp_wr,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [SRC_W-1:0]  snp_src,
  output logic              c2c_supply,
  output logic [ADDR_W-1:0] c2c_addr
);
  import vi_pkg::*;

  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [SRC_W-1:0] OWN_SRC = SRC_W'(MY_ID);

  logic              snoop_go, cpu_go;
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag, st_tag, nx_tag;
  line_state_e       st_state, nx_state;
  logic              st_dirty, nx_dirty, nx_we, hit;

  // one lookup port: a snoop from another cache takes it first
  assign snoop_go  = snp_valid && snoop_en && (snp_src != OWN_SRC);
  assign cpu_go    = cpu_req && !snoop_go;
  assign cpu_stall = cpu_req && snoop_go;

  assign look_addr = snoop_go ? snp_addr : cpu_addr;
  assign look_idx  = look_addr[OFF_W +: IDX_W];
  assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];

  vi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .idx      (look_idx),
    .rd_tag   (st_tag),
    .rd_state (st_state),
    .rd_dirty (st_dirty),
    .wr_en    (nx_we),
    .wr_tag   (nx_tag),
    .wr_state (nx_state),
    .wr_dirty (nx_dirty)
  );

  vi_match #(.TAG_W(TAG_W)) u_match (
    .look_tag    (look_tag),
    .store_tag   (st_tag),
    .store_state (st_state),
    .hit         (hit)
  );

  always_comb begin
    nx_we    = 1'b0;
    nx_tag   = look_tag;
    nx_state = LS_VAL;
    nx_dirty = 1'b0;
    if (snoop_go) begin
      if (hit) begin
        nx_we    = 1'b1;
        nx_state = snp_wr ? LS_INV : LS_VAL;
        nx_dirty = 1'b0;  // data leaves through the transfer
      end
    end else if (cpu_go) begin
      nx_we    = 1'b1;
      nx_state = LS_VAL;
      nx_dirty = hit ? (st_dirty | cpu_wr) : cpu_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ack    <= 1'b0;
      cpu_hit    <= 1'b0;
      bus_valid  <= 1'b0;
      bus_wr     <= 1'b0;
      bus_addr   <= '0;
      c2c_supply <= 1'b0;
      c2c_addr   <= '0;
    end else begin
      cpu_ack    <= cpu_go;
      cpu_hit    <= cpu_go && hit;
      bus_valid  <= cpu_go && (!hit || cpu_wr);
      bus_wr     <= cpu_go && cpu_wr;
      if (cpu_go) bus_addr <= cpu_addr;
      c2c_supply <= snoop_go && hit && st_dirty;
      if (snoop_go) c2c_addr <= snp_addr;
    end
  end
endmodule

// File: rtl/vi_snoop_chk.sv
module vi_snoop_chk #(
  parameter int SRC_W = 3,
  parameter int MY_ID = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             snoop_en,
  input logic             cpu_req,
  input logic             cpu_wr,
  input logic             cpu_stall,
  input logic             cpu_ack,
  input logic             cpu_hit,
  input logic             bus_valid,
  input logic             bus_wr,
  input logic             snp_valid,
  input logic [SRC_W-1:0] snp_src,
  input logic             c2c_supply
);
  logic remote;
  assign remote = snp_valid && (snp_src != SRC_W'(MY_ID));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cpu_ack && !bus_valid && !c2c_supply);  // R1
  AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_stall |=> cpu_ack);  // R2
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
    !(cpu_req && !cpu_stall) |=> !cpu_ack);  // R2
  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (rst)
    cpu_ack && !cpu_hit |-> bus_valid);  // R2
  AST_READ_HIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    cpu_ack && cpu_hit && !$past(cpu_wr) |-> !bus_valid);  // R3
  AST_WRITE_BROADCAST: assert property (@(posedge clk) disable iff (rst)
    cpu_ack && $past(cpu_wr) |-> bus_valid && bus_wr);  // R4
  AST_BUS_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> cpu_ack);  // R2
  AST_OWN_SRC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    snp_valid && !remote |=> !c2c_supply);  // R7
  AST_SUPPLY_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (rst)
    c2c_supply |-> $past(remote) && $past(snoop_en));  // R8
  AST_SNOOP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    cpu_req && remote && snoop_en |-> cpu_stall);  // R9
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> cpu_req && remote);  // R9
  AST_SNOOP_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !snoop_en |-> !cpu_stall);  // R10
  AST_SNOOP_OFF_NO_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    !snoop_en |=> !c2c_supply);  // R10
endmodule

bind vi_snoop_ctrl vi_snoop_chk #(.SRC_W(SRC_W), .MY_ID(MY_ID)) u_chk (
  .clk(clk), .rst(rst), .snoop_en(snoop_en), .cpu_req(cpu_req),
  .cpu_wr(cpu_wr), .cpu_stall(cpu_stall), .cpu_ack(cpu_ack),
  .cpu_hit(cpu_hit), .bus_valid(bus_valid), .bus_wr(bus_wr),
  .snp_valid(snp_valid), .snp_src(snp_src), .c2c_supply(c2c_supply)
);

// File: tb/sim_vi_snoop_ctrl.sv
module sim_vi_snoop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 5;
  localparam int IDX_W  = 4;
  localparam int SRC_W  = 3;
  localparam int MY_ID  = 0;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;

  logic clk = 1'b0, rst = 1'b1, snoop_en = 1'b1;
  logic cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0, snp_addr = '0;
  logic snp_valid = 1'b0, snp_wr = 1'b0;
  logic [SRC_W-1:0] snp_src = '0;
  logic cpu_stall, cpu_ack, cpu_hit, bus_valid, bus_wr, c2c_supply;
  logic [ADDR_W-1:0] bus_addr, c2c_addr;

  int checks = 0, fails = 0;

  // reference model of the line table
  bit               m_val [LINES];
  bit               m_dirty [LINES];
  logic [TAG_W-1:0] m_tag [LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  vi_snoop_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                  .SRC_W(SRC_W), .MY_ID(MY_ID)) u0 (
    .clk(clk), .rst(rst), .snoop_en(snoop_en), .cpu_req(cpu_req),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_stall(cpu_stall),
    .cpu_ack(cpu_ack), .cpu_hit(cpu_hit), .bus_valid(bus_valid),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .snp_valid(snp_valid),
    .snp_wr(snp_wr), .snp_addr(snp_addr), .snp_src(snp_src),
    .c2c_supply(c2c_supply), .c2c_addr(c2c_addr)
  );

  function automatic logic [ADDR_W-1:0] mk(input int t, input int i, input int o);
    return {TAG_W'(t), IDX_W'(i), OFF_W'(o)};
  endfunction

  function automatic int ix(input logic [ADDR_W-1:0] a);
    return int'(a[OFF_W +: IDX_W]);
  endfunction

  function automatic logic [TAG_W-1:0] tg(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // model a local access; returns expected hit
  task automatic model_cpu(input bit w, input logic [ADDR_W-1:0] a, output bit h);
    int i = ix(a);
    h = m_val[i] && (m_tag[i] == tg(a));
    m_dirty[i] = h ? (m_dirty[i] | w) : w;
    m_val[i] = 1'b1;
    m_tag[i] = tg(a);
  endtask

  // check the registered results of one accepted access (call at negedge)
  task automatic check_cpu(input bit w, input logic [ADDR_W-1:0] a, input bit h, input string lbl);
    bit eb = !h || w;
    chk(cpu_ack == 1'b1, {lbl, " R2 ack"}, cpu_ack, 1);
    chk(cpu_hit == h, {lbl, " R3 hit"}, cpu_hit, h);
    chk(bus_valid == eb, {lbl, " R4 bus_valid"}, bus_valid, eb);
    if (eb) begin
      chk(bus_wr == w, {lbl, " R2 bus_wr"}, bus_wr, w);
      chk(bus_addr == a, {lbl, " R2 bus_addr"}, bus_addr, a);
    end
  endtask

  // one step starting just after a falling edge
  task automatic step(input bit cg, input bit cw, input logic [ADDR_W-1:0] ca,
                      input bit sg, input bit sw, input logic [ADDR_W-1:0] sa,
                      input int ss, input bit en, input string lbl);
    bit qual, sup, h;
    int i;
    cpu_req = cg; cpu_wr = cw; cpu_addr = ca;
    snp_valid = sg; snp_wr = sw; snp_addr = sa; snp_src = SRC_W'(ss);
    snoop_en = en;
    #1;
    qual = sg && en && (ss != MY_ID);
    chk(cpu_stall == (cg && qual), {lbl, " R9 stall"}, cpu_stall, cg && qual);
    sup = 1'b0;
    i = ix(sa);
    if (qual && m_val[i] && m_tag[i] == tg(sa)) begin
      sup = m_dirty[i];
      m_dirty[i] = 1'b0;
      if (sw) m_val[i] = 1'b0;
    end
    h = 1'b0;
    if (cg && !qual) model_cpu(cw, ca, h);
    @(posedge clk); @(negedge clk);
    chk(c2c_supply == sup, {lbl, " R8 supply"}, c2c_supply, sup);
    if (sup) chk(c2c_addr == sa, {lbl, " R8 c2c_addr"}, c2c_addr, sa);
    if (cg && !qual) check_cpu(cw, ca, h, lbl);
    else chk(cpu_ack == 1'b0, {lbl, " R9 no ack while stalled"}, cpu_ack, 0);
    snp_valid = 1'b0;
    if (cg && qual) begin
      #1;
      chk(cpu_stall == 1'b0, {lbl, " R9 stall released"}, cpu_stall, 0);
      model_cpu(cw, ca, h);
      @(posedge clk); @(negedge clk);
      check_cpu(cw, ca, h, {lbl, " R9 retry"});
    end
    cpu_req = 1'b0;
  endtask

  // local access only, with explicit expected hit for directed checks
  task automatic acc(input bit w, input logic [ADDR_W-1:0] a, input bit exp_hit, input string lbl);
    chk(m_val[ix(a)] && m_tag[ix(a)] == tg(a) ? exp_hit : !exp_hit, {lbl, " bench model agrees"}, exp_hit, exp_hit);
    step(1'b1, w, a, 1'b0, 1'b0, '0, 1, 1'b1, lbl);
  endtask

  task automatic snp(input bit w, input logic [ADDR_W-1:0] a, input int src, input bit en, input string lbl);
    step(1'b0, 1'b0, '0, 1'b1, w, a, src, en, lbl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) begin m_val[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_ack && !bus_valid && !c2c_supply, "R1 quiet after reset",
        {cpu_ack, bus_valid, c2c_supply}, 0);

    acc(0, mk(1, 2, 4), 0, "R1 R2 read miss");
    acc(0, mk(1, 2, 8), 1, "R3 read hit");
    acc(1, mk(1, 2, 0), 1, "R4 write hit");
    snp(0, mk(1, 2, 0), 3, 1, "R8 R6 remote read of dirty line");
    snp(0, mk(1, 2, 0), 3, 1, "R8 second remote read, clean");
    acc(0, mk(1, 2, 0), 1, "R6 line still valid");
    snp(1, mk(1, 2, 0), 5, 1, "R5 remote write");
    acc(0, mk(1, 2, 0), 0, "R5 miss after invalidate");
    acc(1, mk(2, 7, 0), 0, "R2 write miss");
    snp(1, mk(2, 7, 0), MY_ID, 1, "R7 own source");
    acc(0, mk(2, 7, 0), 1, "R7 line kept");
    snp(1, mk(2, 7, 0), 4, 0, "R10 snoop disabled");
    acc(0, mk(2, 7, 0), 1, "R10 line kept");
    snp(1, mk(3, 7, 0), 4, 1, "R11 tag mismatch snoop");
    acc(0, mk(2, 7, 0), 1, "R11 line kept");
    acc(0, mk(3, 7, 0), 0, "R11 conflict miss");
    acc(0, mk(2, 7, 0), 0, "R11 old tag replaced");
    acc(1, mk(4, 9, 0), 0, "R8 dirty fill");
    step(1, 0, mk(4, 9, 0), 1, 1, mk(4, 9, 0), 2, 1, "R9 R5 collision");
    step(1, 1, mk(5, 1, 0), 1, 0, mk(5, 1, 0), 2, 0, "R10 R9 no stall when off");

    for (int n = 0; n < 600; n++) begin
      int t = int'($urandom_range(1, 3));
      int i = int'($urandom_range(0, 3));
      int st = int'($urandom_range(1, 3));
      int si = int'($urandom_range(0, 3));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, mk(t, i, 0),
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, mk(st, si, 0),
           int'($urandom_range(0, 7)), $urandom_range(0, 7) != 0,
           "R2 R3 R5 R6 R8 random");
    end
    finish_run();
  end
endmodule